// File: doc/BRIEF.md
# Inverse-Cube Lookup Unit

This block turns an unsigned 32-bit sum of squared coordinate differences S into a 16-bit fixed-point approximation of S^(-3/2), the 1/r³ factor of a pairwise Coulomb force. A square root, a reciprocal and a cube collapse into one small table. The table has a 10-bit address and a 16-bit word. Its contents are computed while the design elaborates, so the block needs no memory image.

A 2^32-word table is out of reach, so the input is normalised first. The block finds the smallest n for which S shifted right by 2n fits the table address, and it looks up that window. The table word is then shifted right by 3n. Because the shift before the table is even, the square root of the scale factor is exact: S = k·4^n gives S^(-3/2) = k^(-3/2)·8^(-n). A zero input marks two coincident points. It raises a singular flag and returns 0. The unit takes one input per clock and gives its result three clocks later.

Top module: `inv_cube_lut`

## Requirements
- R1: A result appears on out_vld exactly 3 clock cycles after in_vld is sampled high, and a new input is accepted every cycle, including back-to-back inputs.
- R2: While rst_n is low, and during the cycles after it is released with no input applied, out_vld stays 0.
- R3: An input S = 0 gives out_sing = 1 and out_val = 0.
- R4: Any nonzero input gives out_sing = 0.
- R5: For 1 <= S <= 1023 there is no shift, and out_val equals round(65535·S^(-3/2)) within half an LSB. Examples: S=1 gives 65535, S=2 gives 23170, S=4 gives 8192, S=1023 gives 2.
- R6: For S >= 1024 the block uses the smallest n (0..11) for which floor(S/4^n) < 1024. It sets k = floor(S/4^n) and outputs floor(T(k)/8^n), where T(k) = round(65535·k^(-3/2)). Examples: S=1024 gives 2, S=1100 gives 1, S=4095 gives 0, S=4096 gives 0, S=0xFFFFFFFF gives 0.
- R7: For every nonzero S, |out_val − 65535·S^(-3/2)| <= 0.007·(65535·S^(-3/2)) + 1.5.
- R8: Whenever the shift n is nonzero, the table index has at least one of its two top bits set, so at least 8 significant bits take part in the lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_vld | input | 1 | Input sample valid |
| in_sum | input | 32 | Unsigned sum of squared distances S |
| out_vld | output | 1 | Result valid |
| out_val | output | 16 | Approximation of 65535·S^(-3/2) |
| out_sing | output | 1 | Singular input (S = 0); out_val is 0 |

## Verification
The bench builds the unit with its default parameters: a 32-bit input, a 10-bit index and a 16-bit result. These values make twelve shift amounts, n = 0 through 11, reachable. A full sweep of the unshifted range 1..1023 checks every table word that is used without a shift. Random inputs right-shifted by random amounts land in every normalisation step and are held to the error bound. Directed values sit at the edges where the shift amount changes (1023/1024, 4095/4096, all ones). Zero inputs are mixed into the back-to-back traffic to exercise the singular flag.

// File: rtl/inv3_pkg.sv
package inv3_pkg;

   // Integer square root, floor(sqrt(x)), one result bit per step
   function automatic logic [31:0] isqrt64(input logic [63:0] x);
      logic [31:0] res;
      logic [63:0] t;
      res = '0;
      for (int b = 31; b >= 0; b--) begin
         t = {32'd0, res | (32'd1 << b)};
         if (t * t <= x) res = res | (32'd1 << b);
      end
      return res;
   endfunction

   // round((2^out_w - 1) * k^(-3/2)), computed with integers only
   function automatic logic [31:0] inv_cube_entry(input int k, input int out_w);
      int          frac;
      logic [63:0] kmax, kk, num, x;
      logic [31:0] r;
      frac = (62 - 2 * out_w) / 2;
      kmax = (64'd1 << out_w) - 64'd1;
      if (k == 0) return 32'd0;
      kk  = 64'(k);
      num = (kmax * kmax) << (2 * frac);
      x   = num / (kk * kk * kk);
      r   = isqrt64(x);
      return (r + (32'd1 << (frac - 1))) >> frac;
   endfunction

endpackage

// File: rtl/inv3_norm.sv
module inv3_norm #(
   parameter int IN_W  = 32,
   parameter int IDX_W = 10,
   parameter int NMAX  = 11,
   parameter int SH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [IN_W-1:0]  in_sum,
   output logic             nv_q,
   output logic [IDX_W-1:0] idx_q,
   output logic [SH_W-1:0]  sh_q,
   output logic             zero_q
);

   logic [NMAX-1:0]  fits;
   logic [SH_W-1:0]  sh_c;
   logic [IDX_W-1:0] idx_c;

   // fits[j]: S >> 2j leaves nothing above the index window
   for (genvar j = 0; j < NMAX; j++) begin : g_fit
      assign fits[j] = ~|(in_sum >> (IDX_W + 2 * j));
   end

   // smallest even step that fits
   always_comb begin
      sh_c = SH_W'(NMAX);
      for (int j = NMAX - 1; j >= 0; j--) begin
         if (fits[j]) sh_c = SH_W'(j);
      end
   end

   assign idx_c = IDX_W'(in_sum >> {sh_c, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nv_q <= 1'b0;
      else        nv_q <= in_vld;
   end

   always_ff @(posedge clk) begin
      idx_q  <= idx_c;
      sh_q   <= sh_c;
      zero_q <= ~|in_sum;
   end

   // R8
   norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_q && sh_q != '0) |-> (idx_q[IDX_W-1 -: 2] != 2'b00));

   // R6
   shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nv_q |-> (sh_q <= SH_W'(NMAX)));

endmodule

// File: rtl/inv3_rom.sv
module inv3_rom #(
   parameter int IDX_W = 10,
   parameter int OUT_W = 16,
   parameter int SH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nv_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [SH_W-1:0]  sh_i,
   input  logic             zero_i,
   output logic             lv_q,
   output logic [OUT_W-1:0] word_q,
   output logic [SH_W-1:0]  sh_q,
   output logic             zero_q
);

   localparam int DEPTH = 1 << IDX_W;

   logic [OUT_W-1:0] rom [DEPTH];

   // contents fixed at elaboration
   for (genvar g = 0; g < DEPTH; g++) begin : g_fill
      assign rom[g] = OUT_W'(inv3_pkg::inv_cube_entry(g, OUT_W));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lv_q <= 1'b0;
      else        lv_q <= nv_i;
   end

   always_ff @(posedge clk) begin
      word_q <= rom[idx_i];
      sh_q   <= sh_i;
      zero_q <= zero_i;
   end

   // R5
   word_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_i && !zero_i) |=> (word_q != '0));

endmodule

// File: rtl/inv3_denorm.sv
module inv3_denorm #(
   parameter int OUT_W = 16,
   parameter int SH_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lv_i,
   input  logic [OUT_W-1:0] word_i,
   input  logic [SH_W-1:0]  sh_i,
   input  logic             zero_i,
   output logic             out_vld,
   output logic [OUT_W-1:0] out_val,
   output logic             out_sing
);

   localparam int SH3_W = SH_W + 2;

   logic [SH3_W-1:0] sh3;
   logic [OUT_W-1:0] val_c;

   // 3n = n + 2n
   assign sh3   = SH3_W'(sh_i) + SH3_W'({sh_i, 1'b0});
   assign val_c = zero_i ? '0 : (word_i >> sh3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_vld <= 1'b0;
      else        out_vld <= lv_i;
   end

   always_ff @(posedge clk) begin
      out_val  <= val_c;
      out_sing <= zero_i;
   end

   // R6
   no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lv_i |=> (out_val <= $past(word_i)));

endmodule

// File: rtl/inv_cube_lut.sv
module inv_cube_lut #(
   parameter int IN_W  = 32,
   parameter int IDX_W = 10,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_vld,
   input  logic [IN_W-1:0]  in_sum,
   output logic             out_vld,
   output logic [OUT_W-1:0] out_val,
   output logic             out_sing
);

   localparam int NMAX = (IN_W - IDX_W + 1) / 2;
   localparam int SH_W = $clog2(NMAX + 1);

   if (IDX_W < 4 || IDX_W > 12) begin : g_bad_idx
      $error("inv_cube_lut: IDX_W must lie in 4..12");
   end
   if (IN_W <= IDX_W || IN_W > 64) begin : g_bad_in
      $error("inv_cube_lut: IN_W must exceed IDX_W and be at most 64");
   end
   if (OUT_W < 4 || OUT_W > 24) begin : g_bad_out
      $error("inv_cube_lut: OUT_W must lie in 4..24");
   end

   logic             nv, lv, zn, zl;
   logic [IDX_W-1:0] idx;
   logic [SH_W-1:0]  shn, shl;
   logic [OUT_W-1:0] word;

   inv3_norm #(.IN_W(IN_W), .IDX_W(IDX_W), .NMAX(NMAX), .SH_W(SH_W)) u_norm (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sum(in_sum),
      .nv_q(nv), .idx_q(idx), .sh_q(shn), .zero_q(zn));

   inv3_rom #(.IDX_W(IDX_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_rom (
      .clk(clk), .rst_n(rst_n), .nv_i(nv), .idx_i(idx), .sh_i(shn), .zero_i(zn),
      .lv_q(lv), .word_q(word), .sh_q(shl), .zero_q(zl));

   inv3_denorm #(.OUT_W(OUT_W), .SH_W(SH_W)) u_denorm (
      .clk(clk), .rst_n(rst_n), .lv_i(lv), .word_i(word), .sh_i(shl), .zero_i(zl),
      .out_vld(out_vld), .out_val(out_val), .out_sing(out_sing));

   // R1
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##3 out_vld);

   // R3
   zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_sum == '0) |-> ##3 (out_sing && out_val == '0));

   // R4
   nonzero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_sum != '0) |-> ##3 !out_sing);

endmodule

// File: tb/inv_cube_lut_tb.sv
module inv_cube_lut_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] in_sum = '0;
   logic        out_vld;
   logic [15:0] out_val;
   logic        out_sing;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] s;
      int          cyc;
      bit          exact;
      int          expv;
   } item_t;

   item_t sb[$];
   item_t it;

   inv_cube_lut u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sum(in_sum),
      .out_vld(out_vld), .out_val(out_val), .out_sing(out_sing));

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic send(input logic [31:0] s, input bit exact, input int expv);
      item_t e;
      @(negedge clk);
      in_vld = 1'b1;
      in_sum = s;
      e.s = s; e.cyc = cyc; e.exact = exact; e.expv = expv;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_vld) begin
            if (sb.size() == 0) chk(1'b0, "R1 unexpected out_vld", 1, 0);
            else begin
               real sr, e;
               it = sb.pop_front();
               chk(cyc - it.cyc == 3, "R1 latency", cyc - it.cyc, 3);
               sr = it.s;
               if (it.s == 0) begin
                  chk(out_sing == 1'b1, "R3 singular flag", out_sing, 1);
                  chk(out_val == 16'd0, "R3 zero result", out_val, 0);
               end else begin
                  e = 65535.0 / (sr * $sqrt(sr));
                  chk(out_sing == 1'b0, "R4 flag clear", out_sing, 0);
                  if (it.exact)
                     chk(out_val == 16'(it.expv), "R6 directed value", out_val, it.expv);
                  else if (it.s < 1024)
                     chk((out_val - e <= 0.501) && (e - out_val <= 0.501),
                         "R5 unshifted rounding", out_val, $rtoi(e + 0.5));
                  else
                     chk((out_val - e <= 0.007 * e + 1.5) && (e - out_val <= 0.007 * e + 1.5),
                         "R7 error bound", out_val, $rtoi(e + 0.5));
               end
            end
         end else if (sb.size() != 0 && cyc - sb[0].cyc >= 3) begin
            chk(1'b0, "R1 missing result", 0, 1);
            void'(sb.pop_front());
         end
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R1 watchdog expired: actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // reset with input asserted: R2
      in_vld = 1'b1;
      in_sum = 32'd5;
      repeat (4) @(negedge clk);
      chk(out_vld == 1'b0, "R2 out_vld in reset", out_vld, 0);
      rst_n = 1'b1;
      in_vld = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(out_vld == 1'b0, "R2 out_vld after reset", out_vld, 0);
      end

      // directed, back-to-back
      send(32'd0, 1'b0, 0);            // R3
      send(32'd1, 1'b1, 65535);        // R5
      send(32'd2, 1'b1, 23170);        // R5
      send(32'd4, 1'b1, 8192);         // R5
      send(32'd0, 1'b0, 0);            // R3
      send(32'd1023, 1'b1, 2);         // R5
      send(32'd1024, 1'b1, 2);         // R6
      send(32'd1100, 1'b1, 1);         // R6
      send(32'd4095, 1'b1, 0);         // R6
      send(32'd4096, 1'b1, 0);         // R6
      send(32'hFFFF_FFFF, 1'b1, 0);    // R6
      idle(5);

      // full unshifted sweep, back-to-back: R5, R1
      for (int s = 1; s < 1024; s++) send(32'(s), 1'b0, 0);
      idle(5);

      // random across every shift amount: R7, R4, R3
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom >> $urandom_range(0, 31);
         if ($urandom_range(0, 40) == 0) r = 32'd0;
         send(r, 1'b0, 0);
         if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
      end
      idle(8);

      chk(sb.size() == 0, "R1 all results delivered", sb.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule